// File: doc/BRIEF.md
# Floating-Point to General Register Move Unit

This block carries word and doubleword moves between the general-purpose register file and the floating-point register file. It receives one move per cycle: an opcode, a floating-point register index, the 64-bit general register operand, and the read data the floating-point file returns for that index and the index above it. One cycle later it presents either a general register write value or a set of per-register floating-point write enables with their data.

The floating-point file runs in one of two modes. In narrow mode each register holds 32 bits, so a doubleword spans an even/odd pair. In wide mode each register holds a full 64 bits. Cases with no defined result return fixed poison patterns: odd-index doubleword reads in narrow mode, and the upper half of a word write in wide mode when the legacy variant is selected. A doubleword write to an odd index in narrow mode writes nothing and raises a flag instead.

Top module: `fgmv_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it, `fpr_we`, `gpr_we` and `unpred` are all zero and all data outputs are zero.
- R2: The opcode is 2 bits: 00 word read, 01 doubleword read, 10 word write, 11 doubleword write. A word read returns bits 31:0 of `fpr_rd_n`, sign-extended to 64 bits, on `gpr_wdata` with `gpr_we` high.
- R3: A doubleword read of an even index in narrow mode (`wide_mode`=0) returns `fpr_rd_n1[31:0]` as bits 63:32 and `fpr_rd_n[31:0]` as bits 31:0.
- R4: A doubleword read of an odd index in narrow mode returns 0xDEADC0DE_BAD0BAD0 with `gpr_we` high and `unpred` low.
- R5: A doubleword write to an even index N in narrow mode sets the `fpr_we` bits N and N+1 in the same cycle. `fpr_wdata_lo` carries the GPR bits 31:0 and `fpr_wdata_hi` carries the GPR bits 63:32, each zero-extended.
- R6: A doubleword write to an odd index in narrow mode leaves every `fpr_we` bit low and raises `unpred` for one cycle.
- R7: In wide mode a doubleword read returns all 64 bits of `fpr_rd_n`. A doubleword write sets only `fpr_we` bit N, with the full GPR value on `fpr_wdata_lo`.
- R8: A word write sets only `fpr_we` bit N and puts the GPR bits 31:0 on `fpr_wdata_lo[31:0]`. The upper half is zero in narrow mode. In wide mode it is 0xDEADC0DE when `LEGACY_WORD_WR`=1 (the default) and zero otherwise.
- R9: Data outputs not used by the current operation are zero. A cycle with `op_valid` low produces no enable, no flag and zero data.
- R10: Results appear on the outputs exactly one clock after the operation is presented, and at most one of the two register files is written per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | A move is presented this cycle |
| op | input | 2 | Move opcode (see R2) |
| fpr_idx | input | 5 | Floating-point register index N |
| wide_mode | input | 1 | 1: 64-bit FP registers, 0: 32-bit FP registers |
| gpr_rdata | input | 64 | General register operand for writes |
| fpr_rd_n | input | 64 | FP file read data for register N |
| fpr_rd_n1 | input | 64 | FP file read data for register N+1 |
| fpr_we | output | 32 | Per-register FP write enables |
| fpr_wdata_lo | output | 64 | Write data for register N |
| fpr_wdata_hi | output | 64 | Write data for register N+1 |
| gpr_we | output | 1 | General register write enable |
| gpr_wdata | output | 64 | General register write data |
| unpred | output | 1 | Unpredictable operation flag |

## Verification
The two functions that can land in the same cycle are the low-half and high-half register updates of a narrow-mode doubleword write. Both enable bits and both data buses change on the same edge. The bench drives even-index doubleword writes at the bottom and top of the file and compares the full enable vector and both data buses against a queued expectation in one step. It then drives the odd-index case right after them and expects no enable bit and a raised flag in the next cycle.

// File: rtl/fgmv_pkg.sv
package fgmv_pkg;

    localparam int XLEN   = 64;
    localparam int HALF_W = XLEN / 2;

    typedef enum logic [1:0] {
        MV_WORD_FROM = 2'b00,
        MV_DBL_FROM  = 2'b01,
        MV_WORD_TO   = 2'b10,
        MV_DBL_TO    = 2'b11
    } mv_op_e;

    localparam logic [HALF_W-1:0] POISON_HI = 32'hDEADC0DE;
    localparam logic [HALF_W-1:0] POISON_LO = 32'hBAD0BAD0;

    typedef struct packed {
        logic            gpr_we;
        logic [XLEN-1:0] gpr_data;
    } rd_res_t;

    typedef struct packed {
        logic            we_lo;
        logic            we_hi;
        logic [XLEN-1:0] lo;
        logic [XLEN-1:0] hi;
        logic            unpred;
    } wr_res_t;

    function automatic logic [XLEN-1:0] sext_half(input logic [HALF_W-1:0] v);
        return {{HALF_W{v[HALF_W-1]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] zext_half(input logic [HALF_W-1:0] v);
        return {{HALF_W{1'b0}}, v};
    endfunction

endpackage

// File: rtl/fgmv_rd_path.sv
module fgmv_rd_path
    import fgmv_pkg::*;
(
    input  logic                 valid,
    input  mv_op_e               op,
    input  logic                 idx_odd,
    input  logic                 wide,
    input  logic [XLEN-1:0]      rd_n,
    input  logic [XLEN-1:0]      rd_n1,
    output rd_res_t              res
);
    logic unused_rd_hi;
    assign unused_rd_hi = ^rd_n1[XLEN-1:HALF_W];

    always_comb begin
        res = '0;
        if (valid) begin
            unique case (op)
                MV_WORD_FROM: begin
                    res.gpr_we   = 1'b1;
                    res.gpr_data = sext_half(rd_n[HALF_W-1:0]);
                end
                MV_DBL_FROM: begin
                    res.gpr_we = 1'b1;
                    if (wide)
                        res.gpr_data = rd_n;
                    else if (idx_odd)
                        res.gpr_data = {POISON_HI, POISON_LO};
                    else
                        res.gpr_data = {rd_n1[HALF_W-1:0], rd_n[HALF_W-1:0]};
                end
                default: res = '0;
            endcase
        end
    end
endmodule

// File: rtl/fgmv_wr_path.sv
module fgmv_wr_path
    import fgmv_pkg::*;
#(
    parameter bit LEGACY_WORD_WR = 1'b1
) (
    input  logic                 valid,
    input  mv_op_e               op,
    input  logic                 idx_odd,
    input  logic                 wide,
    input  logic [XLEN-1:0]      gpr,
    output wr_res_t              res
);
    logic [HALF_W-1:0] wide_word_upper;

    generate
        if (LEGACY_WORD_WR) begin : g_legacy
            assign wide_word_upper = POISON_HI;
        end else begin : g_modern
            assign wide_word_upper = '0;
        end
    endgenerate

    always_comb begin
        res = '0;
        if (valid) begin
            unique case (op)
                MV_WORD_TO: begin
                    res.we_lo = 1'b1;
                    res.lo    = wide ? {wide_word_upper, gpr[HALF_W-1:0]}
                                     : zext_half(gpr[HALF_W-1:0]);
                end
                MV_DBL_TO: begin
                    if (wide) begin
                        res.we_lo = 1'b1;
                        res.lo    = gpr;
                    end else if (idx_odd) begin
                        res.unpred = 1'b1;
                    end else begin
                        res.we_lo = 1'b1;
                        res.we_hi = 1'b1;
                        res.lo    = zext_half(gpr[HALF_W-1:0]);
                        res.hi    = zext_half(gpr[XLEN-1:HALF_W]);
                    end
                end
                default: res = '0;
            endcase
        end
    end
endmodule

// File: rtl/fgmv_unit.sv
module fgmv_unit
    import fgmv_pkg::*;
#(
    parameter int NREG           = 32,
    parameter bit LEGACY_WORD_WR = 1'b1,
    localparam int IDX_W         = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 op_valid,
    input  logic [1:0]           op,
    input  logic [IDX_W-1:0]     fpr_idx,
    input  logic                 wide_mode,
    input  logic [XLEN-1:0]      gpr_rdata,
    input  logic [XLEN-1:0]      fpr_rd_n,
    input  logic [XLEN-1:0]      fpr_rd_n1,
    output logic [NREG-1:0]      fpr_we,
    output logic [XLEN-1:0]      fpr_wdata_lo,
    output logic [XLEN-1:0]      fpr_wdata_hi,
    output logic                 gpr_we,
    output logic [XLEN-1:0]      gpr_wdata,
    output logic                 unpred
);
    mv_op_e  op_e;
    rd_res_t rd_res;
    wr_res_t wr_res;
    logic [NREG-1:0] we_nxt;
    logic [IDX_W:0]  idx_up;

    assign op_e   = mv_op_e'(op);
    assign idx_up = {1'b0, fpr_idx} + 1'b1;

    fgmv_rd_path u_rd (
        .valid   (op_valid),
        .op      (op_e),
        .idx_odd (fpr_idx[0]),
        .wide    (wide_mode),
        .rd_n    (fpr_rd_n),
        .rd_n1   (fpr_rd_n1),
        .res     (rd_res)
    );

    fgmv_wr_path #(.LEGACY_WORD_WR(LEGACY_WORD_WR)) u_wr (
        .valid   (op_valid),
        .op      (op_e),
        .idx_odd (fpr_idx[0]),
        .wide    (wide_mode),
        .gpr     (gpr_rdata),
        .res     (wr_res)
    );

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_we
            assign we_nxt[g] = (wr_res.we_lo && (fpr_idx == IDX_W'(g)))
                            || (wr_res.we_hi && (idx_up == (IDX_W+1)'(g)));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            fpr_we       <= '0;
            fpr_wdata_lo <= '0;
            fpr_wdata_hi <= '0;
            gpr_we       <= 1'b0;
            gpr_wdata    <= '0;
            unpred       <= 1'b0;
        end else begin
            fpr_we       <= we_nxt;
            fpr_wdata_lo <= wr_res.lo;
            fpr_wdata_hi <= wr_res.hi;
            gpr_we       <= rd_res.gpr_we;
            gpr_wdata    <= rd_res.gpr_data;
            unpred       <= wr_res.unpred;
        end
    end

    // R6
    unpred_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        unpred |-> (fpr_we == '0));

    // R10
    one_file_chk: assert property (@(posedge clk) disable iff (rst)
        gpr_we |-> (fpr_we == '0 && !unpred));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (fpr_we == '0 && !gpr_we && !unpred));

    // R4
    odd_read_poison_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == 2'b01 && !wide_mode && fpr_idx[0])
        |=> (gpr_we && gpr_wdata == {POISON_HI, POISON_LO}));

    // R7
    wide_dbl_single_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == 2'b11 && wide_mode) |=> ($countones(fpr_we) == 1));

    // R5
    pair_write_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == 2'b11 && !wide_mode && !fpr_idx[0])
        |=> ($countones(fpr_we) == 2));
endmodule

// File: tb/fgmv_unit_test.sv
module fgmv_unit_test;
    import fgmv_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 32;

    typedef struct {
        logic [NREG-1:0] we;
        logic [63:0]     lo;
        logic [63:0]     hi;
        logic            gwe;
        logic [63:0]     gdat;
        logic            unp;
        string           tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [4:0]  fpr_idx = '0;
    logic        wide_mode = 1'b0;
    logic [63:0] gpr_rdata = '0;
    logic [63:0] fpr_rd_n = '0;
    logic [63:0] fpr_rd_n1 = '0;
    logic [NREG-1:0] fpr_we;
    logic [63:0] fpr_wdata_lo, fpr_wdata_hi, gpr_wdata;
    logic        gpr_we, unpred;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    exp_t q[$];

    fgmv_unit uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op(op), .fpr_idx(fpr_idx),
        .wide_mode(wide_mode), .gpr_rdata(gpr_rdata), .fpr_rd_n(fpr_rd_n),
        .fpr_rd_n1(fpr_rd_n1), .fpr_we(fpr_we), .fpr_wdata_lo(fpr_wdata_lo),
        .fpr_wdata_hi(fpr_wdata_hi), .gpr_we(gpr_we), .gpr_wdata(gpr_wdata),
        .unpred(unpred)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic compare(input exp_t e);
        checks++;
        if (fpr_we !== e.we || fpr_wdata_lo !== e.lo || fpr_wdata_hi !== e.hi ||
            gpr_we !== e.gwe || gpr_wdata !== e.gdat || unpred !== e.unp) begin
            fails++;
            $display("FAIL %s: got we=%h lo=%h hi=%h gwe=%b gd=%h unp=%b exp we=%h lo=%h hi=%h gwe=%b gd=%h unp=%b",
                e.tag, fpr_we, fpr_wdata_lo, fpr_wdata_hi, gpr_we, gpr_wdata, unpred,
                e.we, e.lo, e.hi, e.gwe, e.gdat, e.unp);
        end
    endtask

    // drives at negedge, predicts result one clock later (R10)
    task automatic issue(input bit v, input logic [1:0] o, input int idx, input bit w,
                         input logic [63:0] g, input logic [63:0] rn,
                         input logic [63:0] rn1, input string tag);
        exp_t e;
        @(negedge clk);
        op_valid = v; op = o; fpr_idx = 5'(idx); wide_mode = w;
        gpr_rdata = g; fpr_rd_n = rn; fpr_rd_n1 = rn1;
        e.we = '0; e.lo = '0; e.hi = '0; e.gwe = 1'b0; e.gdat = '0; e.unp = 1'b0;
        e.tag = tag;
        if (v) begin
            case (o)
                2'b00: begin
                    e.gwe = 1'b1;
                    e.gdat = {{32{rn[31]}}, rn[31:0]};
                end
                2'b01: begin
                    e.gwe = 1'b1;
                    if (w) e.gdat = rn;
                    else if (idx % 2 == 1) e.gdat = 64'hDEADC0DE_BAD0BAD0;
                    else e.gdat = {rn1[31:0], rn[31:0]};
                end
                2'b10: begin
                    e.we[idx] = 1'b1;
                    e.lo = {(w ? 32'hDEADC0DE : 32'h0), g[31:0]};
                end
                default: begin
                    if (w) begin
                        e.we[idx] = 1'b1; e.lo = g;
                    end else if (idx % 2 == 1) begin
                        e.unp = 1'b1;
                    end else begin
                        e.we[idx] = 1'b1; e.we[idx+1] = 1'b1;
                        e.lo = {32'h0, g[31:0]}; e.hi = {32'h0, g[63:32]};
                    end
                end
            endcase
        end
        q.push_back(e);
    endtask

    // monitor: pop one expectation per clock once driving has begun
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && q.size() > 0) compare(q.pop_front());
        end
    end

    initial begin
        exp_t z;
        repeat (3) @(posedge clk);
        @(negedge clk);
        z.we = '0; z.lo = '0; z.hi = '0; z.gwe = 1'b0; z.gdat = '0; z.unp = 1'b0;
        z.tag = "R1 reset state";
        compare(z);
        rst = 1'b0;
        // R1: the first cycle after reset with nothing presented stays quiet
        issue(0, 2'b00, 0, 0, 64'h0, 64'h0, 64'h0, "R1 after reset");
        issue(1, 2'b00, 3, 0, 64'h0, 64'h12345678_80000001, 64'h0, "R2 word read negative");
        issue(1, 2'b00, 4, 1, 64'h0, 64'hFFFF0000_7FFFFFFF, 64'h0, "R2 word read positive");
        issue(1, 2'b01, 6, 0, 64'h0, 64'hAAAA_AAAA_11112222, 64'hBBBB_BBBB_33334444, "R3 narrow even dbl read");
        issue(1, 2'b01, 7, 0, 64'h0, 64'h55, 64'h66, "R4 narrow odd dbl read");
        issue(1, 2'b11, 0, 0, 64'hCAFEF00D_01234567, 64'h0, 64'h0, "R5 pair write idx0");
        issue(1, 2'b11, 30, 0, 64'h89ABCDEF_FEDCBA98, 64'h0, 64'h0, "R5 pair write idx30");
        issue(1, 2'b11, 5, 0, 64'h1111_2222_3333_4444, 64'h0, 64'h0, "R6 odd dbl write");
        issue(1, 2'b11, 31, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, "R6 odd dbl write idx31");
        issue(1, 2'b01, 9, 1, 64'h0, 64'h0123_4567_89AB_CDEF, 64'h77, "R7 wide dbl read odd idx");
        issue(1, 2'b11, 13, 1, 64'hDEAD_BEEF_0BAD_F00D, 64'h0, 64'h0, "R7 wide dbl write odd idx");
        issue(1, 2'b10, 2, 0, 64'hFFFFFFFF_87654321, 64'h0, 64'h0, "R8 narrow word write");
        issue(1, 2'b10, 17, 1, 64'h00000000_13579BDF, 64'h0, 64'h0, "R8 wide word write");
        issue(0, 2'b11, 4, 0, 64'hFFFF, 64'h1, 64'h2, "R9 idle with write opcode");
        issue(0, 2'b01, 4, 0, 64'h0, 64'h1, 64'h2, "R9 idle with read opcode");
        issue(1, 2'b11, 8, 0, 64'hA5A5A5A5_5A5A5A5A, 64'h0, 64'h0, "R10 pair write back-to-back");
        issue(1, 2'b00, 8, 0, 64'h0, 64'h00000000_7000000F, 64'h0, "R10 read after write");
        issue(0, 2'b00, 0, 0, 64'h0, 64'h0, 64'h0, "R9 trailing idle");
        repeat (3) @(posedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule